// File: doc/BRIEF.md
# Snapshot Counter with Independent Capture Clock

The block is a binary up-counter paired with a holding register. Each has its own clock. The counter advances on its clock while its active-low enable is held low. An active-low clear forces the count to zero at once, with no clock edge needed. The holding register copies the live count on each rising edge of the capture clock. The data outputs always show the holding register, never the live count, so software or downstream logic can read a stable snapshot while counting goes on.

An active-low carry output marks the terminal count, for building wider counters. Two stages chain by driving the second stage's enable from the first stage's carry, with both on a shared counter clock. The data outputs go high-impedance whenever the output enable is high. Counting and captures are not affected by the output enable.

Top module: `snap_counter`

## Requirements
- R1: On each rising edge of `cnt_clk` with `cnt_en_n` low and `clr_n` high, the count rises by one, and 0xFF (all ones) steps to 0x00.
- R2: On each rising edge of `cap_clk`, the holding register takes the count as it stood just before that edge. `q` shows the holding register and never the live count.
- R3: While `clr_n` is low the count is 0x00, from the moment of assertion and without any clock edge.
- R4: While `cnt_en_n` is high, edges of `cnt_clk` leave the count unchanged.
- R5: A change of `cnt_en_n` with no `cnt_clk` edge never changes the count.
- R6: `carry_n` is low exactly when the count is all ones and `cnt_en_n` is low. Otherwise it is high, including during a clear.
- R7: With `out_en_n` high, every bit of `q` is high-impedance. Counting and captures go on, and the newest captured value appears once `out_en_n` returns low.
- R8: When `cnt_clk` and `cap_clk` share one edge, the captured value is one count behind the counter.
- R9: A clear does not alter the holding register. It keeps its last captured value until the next `cap_clk` edge.
- R10: Two stages on a common `cnt_clk`, with the first stage's `carry_n` driving the second stage's `cnt_en_n`, count as one counter of twice the width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cnt_clk | input | 1 | Counter clock, rising edge active |
| cap_clk | input | 1 | Capture clock for the holding register, rising edge active |
| clr_n | input | 1 | Asynchronous counter clear, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| out_en_n | input | 1 | Data output enable, active low; high floats `q` |
| q | output | WIDTH (8) | Holding register contents, or high-impedance |
| carry_n | output | 1 | Terminal-count carry, active low |

## Verification
The live count is not visible at the ports. A wrong count therefore shows up at the next capture-clock edge, as a `q` value that differs from the arithmetic model. It also shows up right away on `carry_n` when the fault crosses the all-ones value. The bench captures after every counter step over more than a full wrap, so a fault in stepping, wrap or carry is seen within one step. A register that latches the post-edge value, or that is disturbed by a clear, gives a `q` that is off by one count or reads zero at the next read. A cascaded pair counted well past the first stage's wrap shows a wrong carry link as a wrong upper byte.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;
  // Default width of one counter stage.
  localparam int unsigned SNAP_DEF_WIDTH = 8;
endpackage

// File: rtl/snapcnt_count.sv
module snapcnt_count #(
  parameter int unsigned WIDTH = snapcnt_pkg::SNAP_DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             clr_ni,
  input  logic             en_ni,
  output logic [WIDTH-1:0] cnt_o,
  output logic             carry_no
);
  localparam logic [WIDTH-1:0] TERMINAL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             step_en;

  // Next-state logic: the enable only qualifies a clock edge.
  assign step_en = ~en_ni;

  always_comb begin
    cnt_d = cnt_q;
    if (step_en) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign carry_no = ~((cnt_q == TERMINAL) & step_en);

  // R3: the count reads zero at any edge seen while clear is held.
  always @(posedge clk_i) begin
    if (!clr_ni) begin
      p_clear_zero_r3: assert (cnt_q == '0)
        else $error("count not zero under clear");
    end
  end

  // R4: a disabled edge holds the count (a clear between edges may zero it).
  p_hold_disabled_r4: assert property (@(posedge clk_i) disable iff (!clr_ni)
    en_ni |=> (cnt_q == $past(cnt_q)) || (cnt_q == '0));

  // R1: an enabled edge advances by one (a clear between edges may zero it).
  p_step_enabled_r1: assert property (@(posedge clk_i) disable iff (!clr_ni)
    !en_ni |=> (cnt_q == $past(cnt_q) + ONE) || (cnt_q == '0));
endmodule

// File: rtl/snapcnt_hold.sv
module snapcnt_hold #(
  parameter int unsigned WIDTH = snapcnt_pkg::SNAP_DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] hold_o
);
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_d;

  // Loads on every capture edge; no reset so a clear never reaches it.
  always_comb hold_d = d_i;

  always_ff @(posedge clk_i) begin
    hold_q <= hold_d;
  end

  assign hold_o = hold_q;

  // R2: the held value is the input sampled at the previous capture edge.
  p_capture_prev_r2: assert property (@(posedge clk_i)
    1'b1 |=> (hold_q == $past(d_i)));
endmodule

// File: rtl/snapcnt_drive.sv
module snapcnt_drive #(
  parameter int unsigned WIDTH = snapcnt_pkg::SNAP_DEF_WIDTH
) (
  input  logic             oe_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] pad_o
);
  // One three-state driver per data line.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign pad_o[b] = oe_ni ? 1'bz : d_i[b];
  end
endmodule

// File: rtl/snap_counter.sv
module snap_counter #(
  parameter int unsigned WIDTH = snapcnt_pkg::SNAP_DEF_WIDTH
) (
  input  logic             cnt_clk,
  input  logic             cap_clk,
  input  logic             clr_n,
  input  logic             cnt_en_n,
  input  logic             out_en_n,
  output logic [WIDTH-1:0] q,
  output logic             carry_n
);
  logic [WIDTH-1:0] live_cnt;
  logic [WIDTH-1:0] held;

  snapcnt_count #(.WIDTH(WIDTH)) u_count (
    .clk_i    (cnt_clk),
    .clr_ni   (clr_n),
    .en_ni    (cnt_en_n),
    .cnt_o    (live_cnt),
    .carry_no (carry_n)
  );

  snapcnt_hold #(.WIDTH(WIDTH)) u_hold (
    .clk_i  (cap_clk),
    .d_i    (live_cnt),
    .hold_o (held)
  );

  snapcnt_drive #(.WIDTH(WIDTH)) u_drive (
    .oe_ni (out_en_n),
    .d_i   (held),
    .pad_o (q)
  );

  // R6: an asserted carry at an edge means the counter wraps to zero.
  p_carry_wraps_r6: assert property (@(posedge cnt_clk) disable iff (!clr_n)
    !carry_n |=> (live_cnt == '0));
endmodule

// File: tb/tb_snap_counter.sv
`timescale 1ns/1ps
module tb_snap_counter;
  localparam int W = 8;
  localparam int MOD = 1 << W;

  logic cnt_clk, cap_clk, clr_n, cnt_en_n, out_en_n;
  tri   [W-1:0] q;
  logic carry_n;

  // Cascade pair
  logic c_clk, c_cap, c_clr_n, lo_en_n;
  tri   [W-1:0] lo_q, hi_q;
  logic lo_carry_n, hi_carry_n;

  int checks = 0, errors = 0;
  int exp_cnt;
  int exp_hold;
  bit done = 0;

  snap_counter #(.WIDTH(W)) dut (
    .cnt_clk(cnt_clk), .cap_clk(cap_clk), .clr_n(clr_n), .cnt_en_n(cnt_en_n),
    .out_en_n(out_en_n), .q(q), .carry_n(carry_n));

  snap_counter #(.WIDTH(W)) u_lo (
    .cnt_clk(c_clk), .cap_clk(c_cap), .clr_n(c_clr_n), .cnt_en_n(lo_en_n),
    .out_en_n(1'b0), .q(lo_q), .carry_n(lo_carry_n));

  snap_counter #(.WIDTH(W)) u_hi (
    .cnt_clk(c_clk), .cap_clk(c_cap), .clr_n(c_clr_n), .cnt_en_n(lo_carry_n),
    .out_en_n(1'b0), .q(hi_q), .carry_n(hi_carry_n));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // 200 MHz pulse: 2.5 ns high, 2.5 ns low.
  task automatic pulse_cnt();
    #2.5 cnt_clk = 1'b1; #2.5 cnt_clk = 1'b0;
    if (cnt_en_n == 1'b0) exp_cnt = (exp_cnt + 1) % MOD;
  endtask

  task automatic pulse_cap();
    #2.5 cap_clk = 1'b1; #2.5 cap_clk = 1'b0;
    exp_hold = exp_cnt;
  endtask

  task automatic pulse_both();
    exp_hold = exp_cnt;
    #2.5 cnt_clk = 1'b1; cap_clk = 1'b1; #2.5 cnt_clk = 1'b0; cap_clk = 1'b0;
    if (cnt_en_n == 1'b0) exp_cnt = (exp_cnt + 1) % MOD;
  endtask

  task automatic chk_carry(input string req);
    #1 chk(req, int'(carry_n), (exp_cnt == MOD-1 && cnt_en_n == 1'b0) ? 0 : 1);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cnt_clk = 0; cap_clk = 0; clr_n = 0; cnt_en_n = 0; out_en_n = 0;
    c_clk = 0; c_cap = 0; c_clr_n = 0; lo_en_n = 0;
    exp_cnt = 0; exp_hold = 0;
    #10;
    // Reset state: clear held, carry high, capture shows zero (R3, R6).
    chk("R6 carry idle under clear", int'(carry_n), 1);
    pulse_cnt(); exp_cnt = 0;
    pulse_cap(); #1 chk("R3 count zero under clear", int'(q), 0);
    clr_n = 1; #3;

    // R1/R2/R6: step through more than a full wrap, capture every step.
    for (int i = 1; i <= MOD + 44; i++) begin
      pulse_cnt();
      chk_carry("R6 carry at step");
      pulse_cap();
      #1 chk("R1 count step/wrap via capture", int'(q), exp_hold);
      chk("R1 model value", exp_hold, i % MOD);
    end

    // R2: output shows held value, not the live count.
    pulse_cnt(); pulse_cnt(); #1;
    chk("R2 q holds snapshot", int'(q), exp_hold);

    // R3: asynchronous clear between clock edges.
    #1 clr_n = 0; #1 clr_n = 1; exp_cnt = 0; #2;
    chk("R9 clear leaves register", int'(q), exp_hold);
    pulse_cap(); #1 chk("R3 async clear zeroes count", int'(q), 0);

    // R4: disabled edges hold; R5: enable toggles alone do nothing.
    for (int i = 0; i < 5; i++) pulse_cnt();
    cnt_en_n = 1;
    for (int i = 0; i < 7; i++) pulse_cnt();
    pulse_cap(); #1 chk("R4 hold while disabled", int'(q), 5);
    for (int i = 0; i < 6; i++) begin #1 cnt_en_n = ~cnt_en_n; end
    #1 cnt_en_n = 1;
    pulse_cap(); #1 chk("R5 enable toggles no step", int'(q), 5);
    cnt_en_n = 0;

    // R6: carry follows enable at terminal count.
    while (exp_cnt != MOD-1) pulse_cnt();
    chk_carry("R6 carry at terminal enabled");
    cnt_en_n = 1; chk_carry("R6 carry released by enable");
    cnt_en_n = 0; chk_carry("R6 carry reasserted");
    #1 clr_n = 0; exp_cnt = 0; #1;
    chk("R6 carry released by clear", int'(carry_n), 1);
    clr_n = 1; #2;

    // R8: tied clocks capture the pre-edge count.
    for (int i = 0; i < 20; i++) begin
      pulse_both();
      #1 chk("R8 tied clocks one behind", int'(q), exp_hold);
      chk("R8 model lag", exp_hold, (exp_cnt + MOD - 1) % MOD);
    end

    // R7: float while counting, then re-enable.
    out_en_n = 1; #1;
    checks++;
    if (q !== {W{1'bz}}) begin
      errors++; $display("FAIL R7 float: actual %b expected all z", q);
    end
    for (int i = 0; i < 3; i++) pulse_cnt();
    pulse_cap(); #1;
    checks++;
    if (q !== {W{1'bz}}) begin
      errors++; $display("FAIL R7 float after capture: actual %b expected all z", q);
    end
    out_en_n = 0; #1 chk("R7 re-enabled shows new capture", int'(q), exp_hold);

    // R9: clear keeps the register after a fresh capture.
    pulse_cnt(); pulse_cap();
    #1 clr_n = 0; #2 chk("R9 register survives clear", int'(q), exp_hold);
    clr_n = 1; exp_cnt = 0; #2;

    // R10: cascade two stages across several low-stage wraps.
    #2 c_clr_n = 1; #2;
    for (int i = 1; i <= 700; i++) begin
      #2.5 c_clk = 1; #2.5 c_clk = 0;
      if (i % 97 == 0 || i == 700 || i == 256 || i == 255) begin
        #2.5 c_cap = 1; #2.5 c_cap = 0; #1;
        chk("R10 cascade value", (int'(hi_q) << W) | int'(lo_q), i);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule